// File: doc/BRIEF.md
# Control and Debug Register File

This block holds the machine control registers (CR0, CR2, CR3, CR4, CR8), the extended feature register, the eight debug register indices, a time-stamp counter, a floating-point status word and the floating-point stack-top field. Software-side logic writes it through an index/data port and reads it through a second index port with a combinational data return. A write is not a plain store. Depending on the index it can:
- switch long mode on or off,
- force or preserve bits,
- redirect to an aliased register,
- request a flush of the translation buffers,
- ask the mode decoder to recompute.

The long-mode-active bit is driven straight to the core. The flush-all and flush-non-global pulses go to both the instruction and the data translation buffers. A reserved control register index raises a one-cycle error pulse, and the access has no effect. A sticky flag records any attempt to arm a hardware breakpoint, because breakpoint matching is not provided.

Index map:

| Range | Contents |
|---|---|
| 0 to 15 | CR0 to CR15 |
| 16 to 23 | DR0 to DR7 |
| 24 | extended feature register |
| 25 | time-stamp counter |
| 26 | FP status word |
| 27 | FP stack top |

Indices 28 to 31 read zero and ignore writes.

Top module: `ctrl_dbg_regfile`

## Requirements
- R1: After reset every register reads zero except three. DR6 reads 0xFFFF0FF0, DR7 reads 0x400 and CR0 reads 0x10. The time-stamp counter reads the current `curCycle`, and `lmaActive`, all pulses and the breakpoint flag are 0.
- R2: When a CR0 write changes bit 31 (paging) while bit 8 of the extended feature register is 1, bit 10 of that register (and `lmaActive`) takes the new bit 31 value. Without bit 8 set, or without a change of bit 31, long mode is unchanged. A direct write of the extended feature register stores all bits.
- R3: A CR0 write that changes bit 31 gives a one-cycle `flushAll` pulse in the cycle after the write. A CR0 write that leaves bit 31 unchanged gives none.
- R4: CR0 bit 4 always reads 1, whatever value was written.
- R5: Every write to CR3 (index 3) gives a one-cycle `flushNonGlobal` pulse in the cycle after the write, and no `flushAll`.
- R6: A CR4 write that changes bit 4, bit 5 or bit 7 gives a one-cycle `flushAll` pulse in the next cycle. Changes in other CR4 bits give none.
- R7: Index 20 (DR4) reads and writes DR6, and index 21 (DR5) reads and writes DR7.
- R8: A DR6 write changes only bits 0 to 3, 13, 14 and 15 (mask 0xE00F). Every other DR6 bit keeps its value.
- R9: A DR7 write changes only bits 0 to 7, bit 13 and bits 16 to 31, and bit 10 stays 1. A DR7 write with any of bits 0 to 7 set raises `bkptUnsupported` in the next cycle, which stays high until reset while the bits are still stored.
- R10: The time-stamp counter stores the written value minus `curCycle` at the write. A read returns the stored offset plus the present `curCycle`.
- R11: A read of the FP status word returns the stored word with bits 13:11 replaced by the 3-bit stack top (index 27, bits 2:0).
- R12: A write or a read-enabled access to index 1, 5 to 7 or 9 to 15 gives a one-cycle `illegalAccess` pulse in the next cycle. Such a write changes no register, and such a read returns zero.
- R13: Every CR0 write gives a one-cycle `modeRecompute` pulse in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrIdx | input | 5 | Write register index |
| wrData | input | XLEN | Write data |
| rdEn | input | 1 | Read strobe, used only to flag reserved-index reads |
| rdIdx | input | 5 | Read register index |
| rdData | output | XLEN | Combinational read data for rdIdx |
| curCycle | input | XLEN | Current cycle count for the time-stamp counter |
| lmaActive | output | 1 | Long mode active |
| flushAll | output | 1 | Flush-all pulse to both translation buffers |
| flushNonGlobal | output | 1 | Flush-non-global pulse to both translation buffers |
| modeRecompute | output | 1 | Request to the mode decoder to recompute |
| illegalAccess | output | 1 | Reserved control register index accessed |
| bkptUnsupported | output | 1 | Sticky: a breakpoint enable was written |

## Verification
Register contents, including `lmaActive`, change at the clock edge that takes the write. `rdData` is combinational, so a read set up on the next falling edge shows the new value. Every pulse (`flushAll`, `flushNonGlobal`, `modeRecompute`, `illegalAccess`) is registered once: it is high in exactly the cycle that follows the write edge, and `bkptUnsupported` rises at that same edge. Each bench task drives on a falling edge and waits one full cycle, then samples pulses and read data at the next falling edge. For the one-cycle property it samples again one cycle later, after an idle cycle.

// File: rtl/ctrl_dbg_pkg.sv
package ctrl_dbg_pkg;

  localparam int IDX_W = 5;

  // Register index map
  localparam logic [IDX_W-1:0] IDX_CR0   = 5'd0;
  localparam logic [IDX_W-1:0] IDX_CR2   = 5'd2;
  localparam logic [IDX_W-1:0] IDX_CR3   = 5'd3;
  localparam logic [IDX_W-1:0] IDX_CR4   = 5'd4;
  localparam logic [IDX_W-1:0] IDX_CR8   = 5'd8;
  localparam logic [IDX_W-1:0] IDX_DR0   = 5'd16;
  localparam logic [IDX_W-1:0] IDX_DR1   = 5'd17;
  localparam logic [IDX_W-1:0] IDX_DR2   = 5'd18;
  localparam logic [IDX_W-1:0] IDX_DR3   = 5'd19;
  localparam logic [IDX_W-1:0] IDX_DR4   = 5'd20;
  localparam logic [IDX_W-1:0] IDX_DR5   = 5'd21;
  localparam logic [IDX_W-1:0] IDX_DR6   = 5'd22;
  localparam logic [IDX_W-1:0] IDX_DR7   = 5'd23;
  localparam logic [IDX_W-1:0] IDX_EFER  = 5'd24;
  localparam logic [IDX_W-1:0] IDX_TSC   = 5'd25;
  localparam logic [IDX_W-1:0] IDX_FSW   = 5'd26;
  localparam logic [IDX_W-1:0] IDX_FPTOP = 5'd27;

  // Bit positions that neighbours decode
  localparam int CR0_ET_BIT   = 4;
  localparam int CR0_PG_BIT   = 31;
  localparam int EFER_LME_BIT = 8;
  localparam int EFER_LMA_BIT = 10;
  localparam int FSW_TOP_LO   = 11;
  localparam int FP_TOP_W     = 3;

  localparam logic [31:0] CR4_FLUSH_MASK = 32'h0000_00B0; // PSE, PAE, PGE
  localparam logic [31:0] DR6_WR_MASK    = 32'h0000_E00F;
  localparam logic [31:0] DR7_WR_MASK    = 32'hFFFF_20FF;
  localparam logic [31:0] DR6_RESET      = 32'hFFFF_0FF0;
  localparam logic [31:0] DR7_RESET      = 32'h0000_0400;
  localparam logic [31:0] DR7_ENABLES    = 32'h0000_00FF;

  // Strobes from control to datapath
  typedef struct packed {
    logic cr0;
    logic cr2;
    logic cr3;
    logic cr4;
    logic cr8;
    logic drLow;
    logic dr6;
    logic dr7;
    logic efer;
    logic tsc;
    logic fsw;
    logic fpTop;
    logic lmaSet;
    logic lmaClr;
  } wrStrobe_t;

  function automatic logic isReservedCr(input logic [IDX_W-1:0] idx);
    return (idx == 5'd1) || (idx >= 5'd5 && idx <= 5'd7) ||
           (idx >= 5'd9 && idx <= 5'd15);
  endfunction

endpackage

// File: rtl/ctrl_dbg_ctrl.sv
module ctrl_dbg_ctrl
  import ctrl_dbg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [XLEN-1:0]        wrData,
  input  logic                   rdEn,
  input  logic [IDX_W-1:0]       rdIdx,
  input  logic [XLEN-1:0]        cr0Q,
  input  logic [XLEN-1:0]        cr4Q,
  input  logic [XLEN-1:0]        eferQ,
  output wrStrobe_t              strobe,
  output logic                   flushAll,
  output logic                   flushNonGlobal,
  output logic                   modeRecompute,
  output logic                   illegalAccess,
  output logic                   bkptUnsupported
);

  localparam logic [XLEN-1:0] PG_MASK   = XLEN'(1) << CR0_PG_BIT;
  localparam logic [XLEN-1:0] LME_MASK  = XLEN'(1) << EFER_LME_BIT;
  localparam logic [XLEN-1:0] CR4_MASK  = XLEN'(CR4_FLUSH_MASK);
  localparam logic [XLEN-1:0] BKPT_MASK = XLEN'(DR7_ENABLES);

  logic pgToggle, cr4Toggle, lmeOn, newPg;
  logic flushAllNext, flushNgNext, modeNext, illegalNext, bkptNext;

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (wrIdx)
        IDX_CR0:                             strobe.cr0   = 1'b1;
        IDX_CR2:                             strobe.cr2   = 1'b1;
        IDX_CR3:                             strobe.cr3   = 1'b1;
        IDX_CR4:                             strobe.cr4   = 1'b1;
        IDX_CR8:                             strobe.cr8   = 1'b1;
        IDX_DR0, IDX_DR1, IDX_DR2, IDX_DR3:  strobe.drLow = 1'b1;
        IDX_DR4, IDX_DR6:                    strobe.dr6   = 1'b1;
        IDX_DR5, IDX_DR7:                    strobe.dr7   = 1'b1;
        IDX_EFER:                            strobe.efer  = 1'b1;
        IDX_TSC:                             strobe.tsc   = 1'b1;
        IDX_FSW:                             strobe.fsw   = 1'b1;
        IDX_FPTOP:                           strobe.fpTop = 1'b1;
        default: ;
      endcase
    end
    pgToggle  = strobe.cr0 && |((cr0Q ^ wrData) & PG_MASK);
    lmeOn     = |(eferQ & LME_MASK);
    newPg     = |(wrData & PG_MASK);
    strobe.lmaSet = pgToggle && lmeOn && newPg;
    strobe.lmaClr = pgToggle && lmeOn && !newPg;
    cr4Toggle = strobe.cr4 && |((cr4Q ^ wrData) & CR4_MASK);
    flushAllNext = pgToggle || cr4Toggle;
    flushNgNext  = strobe.cr3;
    modeNext     = strobe.cr0;
    illegalNext  = (wrEn && isReservedCr(wrIdx)) || (rdEn && isReservedCr(rdIdx));
    bkptNext     = strobe.dr7 && |(wrData & BKPT_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushAll        <= 1'b0;
      flushNonGlobal  <= 1'b0;
      modeRecompute   <= 1'b0;
      illegalAccess   <= 1'b0;
      bkptUnsupported <= 1'b0;
    end else begin
      flushAll       <= flushAllNext;
      flushNonGlobal <= flushNgNext;
      modeRecompute  <= modeNext;
      illegalAccess  <= illegalNext;
      if (bkptNext) bkptUnsupported <= 1'b1;
    end
  end

endmodule

// File: rtl/ctrl_dbg_datapath.sv
module ctrl_dbg_datapath
  import ctrl_dbg_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NUM_BKPT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [XLEN-1:0]  wrData,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [XLEN-1:0]  curCycle,
  output logic [XLEN-1:0]  rdData,
  output logic [XLEN-1:0]  cr0Q,
  output logic [XLEN-1:0]  cr4Q,
  output logic [XLEN-1:0]  eferQ
);

  localparam int BK_W = $clog2(NUM_BKPT);
  localparam logic [XLEN-1:0] ET_MASK  = XLEN'(1) << CR0_ET_BIT;
  localparam logic [XLEN-1:0] DR6_MASK = XLEN'(DR6_WR_MASK);
  localparam logic [XLEN-1:0] DR7_MASK = XLEN'(DR7_WR_MASK);
  localparam logic [XLEN-1:0] TOP_MASK = XLEN'((1 << FP_TOP_W) - 1) << FSW_TOP_LO;

  logic [XLEN-1:0] cr2Q, cr3Q, cr8Q, dr6Q, dr7Q, tscOffQ, fswQ;
  logic [FP_TOP_W-1:0] fpTopQ;
  logic [XLEN-1:0] drLowQ [NUM_BKPT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cr0Q    <= '0;
      cr2Q    <= '0;
      cr3Q    <= '0;
      cr4Q    <= '0;
      cr8Q    <= '0;
      dr6Q    <= XLEN'(DR6_RESET);
      dr7Q    <= XLEN'(DR7_RESET);
      eferQ   <= '0;
      tscOffQ <= '0;
      fswQ    <= '0;
      fpTopQ  <= '0;
    end else begin
      if (strobe.cr0)   cr0Q    <= wrData | ET_MASK;
      if (strobe.cr2)   cr2Q    <= wrData;
      if (strobe.cr3)   cr3Q    <= wrData;
      if (strobe.cr4)   cr4Q    <= wrData;
      if (strobe.cr8)   cr8Q    <= wrData;
      if (strobe.dr6)   dr6Q    <= (dr6Q & ~DR6_MASK) | (wrData & DR6_MASK);
      if (strobe.dr7)   dr7Q    <= (dr7Q & ~DR7_MASK) | (wrData & DR7_MASK);
      if (strobe.tsc)   tscOffQ <= wrData - curCycle;
      if (strobe.fsw)   fswQ    <= wrData;
      if (strobe.fpTop) fpTopQ  <= wrData[FP_TOP_W-1:0];
      if (strobe.efer)        eferQ               <= wrData;
      else if (strobe.lmaSet) eferQ[EFER_LMA_BIT] <= 1'b1;
      else if (strobe.lmaClr) eferQ[EFER_LMA_BIT] <= 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BKPT; b++) begin : g_bkptAddr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                            drLowQ[b] <= '0;
      else if (strobe.drLow && wrIdx[BK_W-1:0] == BK_W'(b)) drLowQ[b] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdIdx)
      IDX_CR0:                            rdData = cr0Q | ET_MASK;
      IDX_CR2:                            rdData = cr2Q;
      IDX_CR3:                            rdData = cr3Q;
      IDX_CR4:                            rdData = cr4Q;
      IDX_CR8:                            rdData = cr8Q;
      IDX_DR0, IDX_DR1, IDX_DR2, IDX_DR3: rdData = drLowQ[rdIdx[BK_W-1:0]];
      IDX_DR4, IDX_DR6:                   rdData = dr6Q;
      IDX_DR5, IDX_DR7:                   rdData = dr7Q;
      IDX_EFER:                           rdData = eferQ;
      IDX_TSC:                            rdData = tscOffQ + curCycle;
      IDX_FSW:                            rdData = (fswQ & ~TOP_MASK) |
                                                   (XLEN'(fpTopQ) << FSW_TOP_LO);
      IDX_FPTOP:                          rdData = XLEN'(fpTopQ);
      default: ;
    endcase
  end

endmodule

// File: rtl/ctrl_dbg_regfile.sv
module ctrl_dbg_regfile
  import ctrl_dbg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [XLEN-1:0]  wrData,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [XLEN-1:0]  rdData,
  input  logic [XLEN-1:0]  curCycle,
  output logic             lmaActive,
  output logic             flushAll,
  output logic             flushNonGlobal,
  output logic             modeRecompute,
  output logic             illegalAccess,
  output logic             bkptUnsupported
);

  wrStrobe_t strobe;
  logic [XLEN-1:0] cr0Q, cr4Q, eferQ;

  ctrl_dbg_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdEn(rdEn), .rdIdx(rdIdx), .cr0Q(cr0Q), .cr4Q(cr4Q), .eferQ(eferQ),
    .strobe(strobe), .flushAll(flushAll), .flushNonGlobal(flushNonGlobal),
    .modeRecompute(modeRecompute), .illegalAccess(illegalAccess),
    .bkptUnsupported(bkptUnsupported)
  );

  ctrl_dbg_datapath #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .curCycle(curCycle), .rdData(rdData),
    .cr0Q(cr0Q), .cr4Q(cr4Q), .eferQ(eferQ)
  );

  assign lmaActive = eferQ[EFER_LMA_BIT];

endmodule

// File: rtl/ctrl_dbg_checker.sv
module ctrl_dbg_checker
  import ctrl_dbg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrIdx,
  input logic             rdEn,
  input logic             lmaActive,
  input logic             flushAll,
  input logic             flushNonGlobal,
  input logic             modeRecompute,
  input logic             illegalAccess,
  input logic             bkptUnsupported
);

  // R2: long mode changes only as a result of a write
  assert_lma_by_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lmaActive != $past(lmaActive)) |-> $past(wrEn));

  // R3 / R6: flush-all only follows a CR0 or CR4 write
  assert_flush_all_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> ($past(wrEn) && ($past(wrIdx) == IDX_CR0 || $past(wrIdx) == IDX_CR4)));

  // R5: flush-non-global follows a CR3 write
  assert_flush_ng_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    flushNonGlobal |-> ($past(wrEn) && $past(wrIdx) == IDX_CR3));

  // R5: a CR3 write always produces the pulse
  assert_flush_ng_due_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == IDX_CR3) |=> flushNonGlobal);

  // R13: every CR0 write requests a mode recompute
  assert_mode_due_R13: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == IDX_CR0) |=> modeRecompute);

  // R12: illegal pulse only after an access
  assert_illegal_source_R12: assert property (@(posedge clk) disable iff (!rstN)
    illegalAccess |-> ($past(wrEn) || $past(rdEn)));

  // R9: breakpoint flag is sticky
  assert_bkpt_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(bkptUnsupported));

endmodule

bind ctrl_dbg_regfile ctrl_dbg_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .rdEn(rdEn),
  .lmaActive(lmaActive), .flushAll(flushAll), .flushNonGlobal(flushNonGlobal),
  .modeRecompute(modeRecompute), .illegalAccess(illegalAccess),
  .bkptUnsupported(bkptUnsupported)
);

// File: tb/ctrl_dbg_regfile_tb.sv
module ctrl_dbg_regfile_tb;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [4:0]      wrIdx = '0;
  logic [XLEN-1:0] wrData = '0;
  logic            rdEn = 1'b0;
  logic [4:0]      rdIdx = '0;
  logic [XLEN-1:0] rdData;
  logic [XLEN-1:0] curCycle = '0;
  logic lmaActive, flushAll, flushNonGlobal, modeRecompute, illegalAccess, bkptUnsupported;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctrl_dbg_regfile #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdData(rdData), .curCycle(curCycle),
    .lmaActive(lmaActive), .flushAll(flushAll), .flushNonGlobal(flushNonGlobal),
    .modeRecompute(modeRecompute), .illegalAccess(illegalAccess),
    .bkptUnsupported(bkptUnsupported)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive a write on a falling edge; returns on the falling edge after the
  // write edge, where the registered pulses are visible.
  task automatic writeReg(input logic [4:0] idx, input logic [XLEN-1:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] idx, output logic [XLEN-1:0] val);
    rdIdx = idx;
    #1 val = rdData;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic expectRead(input string tag, input logic [4:0] idx, input logic [XLEN-1:0] exp);
    logic [XLEN-1:0] v;
    readReg(idx, v);
    check(tag, v, exp);
  endtask

  task automatic testReset();
    expectRead("R1 CR0 reset", 5'd0, 64'h10);
    expectRead("R1 CR3 reset", 5'd3, 64'h0);
    expectRead("R1 DR6 reset", 5'd22, 64'hFFFF_0FF0);
    expectRead("R1 DR7 reset", 5'd23, 64'h400);
    expectRead("R1 EFER reset", 5'd24, 64'h0);
    expectRead("R1 TSC reset", 5'd25, 64'h0);
    check("R1 pulses reset", {lmaActive, flushAll, flushNonGlobal, modeRecompute,
          illegalAccess, bkptUnsupported}, 64'h0);
  endtask

  task automatic testCr0NoLme();
    writeReg(5'd0, 64'h8000_0001);
    check("R3 PG toggle flush", flushAll, 1'b1);
    check("R13 mode recompute", modeRecompute, 1'b1);
    check("R2 no LME keeps LMA", lmaActive, 1'b0);
    idle();
    check("R3 flush single cycle", flushAll, 1'b0);
    check("R13 single cycle", modeRecompute, 1'b0);
    writeReg(5'd0, 64'h8000_0003);
    check("R3 no PG toggle no flush", flushAll, 1'b0);
    check("R13 mode on every CR0 write", modeRecompute, 1'b1);
  endtask

  task automatic testLongMode();
    writeReg(5'd24, 64'h100);
    check("R2 EFER store no LMA", lmaActive, 1'b0);
    writeReg(5'd0, 64'h1);
    check("R2 PG off keeps LMA 0", lmaActive, 1'b0);
    check("R3 PG off flush", flushAll, 1'b1);
    writeReg(5'd0, 64'h8000_0001);
    check("R2 PG on sets LMA", lmaActive, 1'b1);
    expectRead("R2 EFER bit10", 5'd24, 64'h500);
    writeReg(5'd0, 64'h8000_0011);
    check("R2 no toggle keeps LMA", lmaActive, 1'b1);
    writeReg(5'd0, 64'h0);
    check("R2 PG off clears LMA", lmaActive, 1'b0);
    expectRead("R4 ET reads one", 5'd0, 64'h10);
  endtask

  task automatic testCr3Cr4();
    writeReg(5'd3, 64'hABCD_E000);
    check("R5 CR3 flush non-global", flushNonGlobal, 1'b1);
    check("R5 CR3 no flush-all", flushAll, 1'b0);
    expectRead("R5 CR3 value", 5'd3, 64'hABCD_E000);
    idle();
    check("R5 single cycle", flushNonGlobal, 1'b0);
    writeReg(5'd4, 64'h20);
    check("R6 PAE toggle", flushAll, 1'b1);
    writeReg(5'd4, 64'h220);
    check("R6 other bit no flush", flushAll, 1'b0);
    writeReg(5'd4, 64'h2A0);
    check("R6 PGE toggle", flushAll, 1'b1);
    writeReg(5'd4, 64'h2B0);
    check("R6 PSE toggle", flushAll, 1'b1);
  endtask

  task automatic testDebug();
    writeReg(5'd20, 64'hFFFF_FFFF_FFFF_FFFF);
    expectRead("R7 R8 DR4 alias masked", 5'd22, 64'hFFFF_EFFF);
    expectRead("R7 DR4 read alias", 5'd20, 64'hFFFF_EFFF);
    writeReg(5'd22, 64'h0);
    expectRead("R8 DR6 others kept", 5'd22, 64'hFFFF_0FF0);
    writeReg(5'd21, 64'h00FF_2000);
    expectRead("R7 R9 DR5 alias", 5'd23, 64'h00FF_2400);
    expectRead("R7 DR5 read alias", 5'd21, 64'h00FF_2400);
    check("R9 no enable no flag", bkptUnsupported, 1'b0);
    writeReg(5'd23, 64'h1);
    check("R9 enable sets flag", bkptUnsupported, 1'b1);
    expectRead("R9 enable stored", 5'd23, 64'h401);
    writeReg(5'd23, 64'h0);
    check("R9 flag sticky", bkptUnsupported, 1'b1);
    expectRead("R9 bit10 kept", 5'd23, 64'h400);
    writeReg(5'd18, 64'h1234);
    expectRead("R7 DR2 plain", 5'd18, 64'h1234);
    expectRead("R7 DR1 untouched", 5'd17, 64'h0);
  endtask

  task automatic testTscFsw();
    curCycle = 64'd100;
    writeReg(5'd25, 64'd500);
    expectRead("R10 TSC same cycle", 5'd25, 64'd500);
    curCycle = 64'd1000;
    expectRead("R10 TSC advanced", 5'd25, 64'd1400);
    writeReg(5'd26, 64'hFFFF);
    writeReg(5'd27, 64'h5);
    expectRead("R11 FSW top merged", 5'd26, 64'hEFFF);
    expectRead("R11 top readback", 5'd27, 64'h5);
  endtask

  task automatic testReserved();
    writeReg(5'd5, 64'hAB);
    check("R12 CR5 write flagged", illegalAccess, 1'b1);
    expectRead("R12 CR5 reads zero", 5'd5, 64'h0);
    expectRead("R12 CR4 untouched", 5'd4, 64'h2B0);
    expectRead("R12 CR0 untouched", 5'd0, 64'h10);
    idle();
    check("R12 single cycle", illegalAccess, 1'b0);
    writeReg(5'd1, 64'hFFFF);
    check("R12 CR1 write flagged", illegalAccess, 1'b1);
    @(negedge clk);
    rdEn = 1'b1; rdIdx = 5'd9;
    @(negedge clk);
    rdEn = 1'b0;
    check("R12 CR9 read flagged", illegalAccess, 1'b1);
    rdEn = 1'b1; rdIdx = 5'd2;
    @(negedge clk);
    rdEn = 1'b0;
    check("R12 CR2 read not flagged", illegalAccess, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCr0NoLme();
    testLongMode();
    testCr3Cr4();
    testDebug();
    testTscFsw();
    testReserved();
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule